// File: doc/BRIEF.md
# Table-driven paired-pixel TMDS symbol encoder

This block turns pairs of 6-bit colour values into 10-bit transmission symbols through a loadable symbol table, with no encoding logic of its own. Each table entry carries a 10-bit symbol and a small signed disparity. The disparity is what the symbol adds to the DC imbalance of the line. The block keeps one running-disparity accumulator per lane. The sign of that accumulator picks which half of the table the next colour of that lane is looked up in, so the table contents steer the line back toward balance.

Pixels arrive two at a time. The even-position pixel uses one lane and the odd-position pixel uses the other, so the output is two interleaved streams, each balanced on its own. The result is electrically sound but does not match a conventional bit-serial TMDS encoder bit for bit. A line-clear input zeroes both accumulators at the start of each scanline. When balance feedback is switched off, the lanes are pinned to opposite halves of the table and nothing is accumulated. A write port loads or patches the table at any time.

Top module: `lut_tmds_pair_enc`

## Requirements
- R1: A table entry holds the symbol in bits [9:0] and the disparity, as a 6-bit two's-complement value, in bits [15:10]. The table address is {sign, colour}: bit 6 is 1 when the lane's accumulator is negative, and bits [5:0] are the colour.
- R2: A pair presented with in_valid high is accepted in that cycle, and pairs may arrive every cycle. Its symbols appear with out_valid two clock edges later: the even symbol in out_sym[9:0] and the odd symbol in out_sym[19:10]. out_sym holds its value while out_valid is low.
- R3: With bal_en high, the disparity of each entry read is added to its lane's accumulator. The very next pixel of that lane, even if it arrives in the following cycle, is looked up with the updated sign.
- R4: The even and odd lanes have separate accumulators, and neither lane's disparities affect the other lane's lookups.
- R5: clr_line sets both accumulators to zero. A pixel pair presented in the same cycle is looked up with a zero accumulator, and the disparity of the pair still in flight is discarded.
- R6: With bal_en low, even pixels use address bit 6 = 0 and odd pixels use bit 6 = 1, and both accumulators hold their values.
- R7: The accumulators are 12-bit signed and saturate at +2047 and -2048 instead of wrapping.
- R8: A table write in a given cycle is seen by lookups presented in later cycles. A lookup of the same address in the same cycle returns the previous contents.
- R9: After reset, out_valid and out_sym are 0 and both accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_line | input | 1 | Zero both disparity accumulators (scanline start) |
| bal_en | input | 1 | Balance feedback enable |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 7 | Table write address {sign, colour} |
| tbl_wdata | input | 16 | Table entry {disparity, symbol} |
| in_valid | input | 1 | Pixel pair valid |
| in_pix | input | 12 | Even colour [5:0], odd colour [11:6] |
| out_valid | output | 1 | Symbol pair valid |
| out_sym | output | 20 | Even symbol [9:0], odd symbol [19:10] |

## Verification
The assertions assume that the table has been written before any pixel is presented. They also assume that bal_en does not change while a pair is in flight, since the check on accumulator steps and the check that accumulators hold both rely on a loaded table and on a steady feedback mode. The stimulus loads every table entry before the first pixel and changes bal_en only in idle gaps. Random disparities are drawn so that the non-negative half of the table pulls the accumulator down and the negative half pulls it up. Saturation is reached only in a directed run that fills the table with the largest positive disparity and then with the most negative one.

// File: rtl/lte_pkg.sv
package lte_pkg;
  typedef enum logic {LANE_EVEN = 1'b0, LANE_ODD = 1'b1} lane_e;
endpackage

// File: rtl/lte_tbl_ram.sv
module lte_tbl_ram #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-first: a same-cycle write is not seen by this read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lte_lane.sv
module lte_lane import lte_pkg::*; #(
  parameter int    COLOR_W = 6,
  parameter int    SYM_W   = 10,
  parameter int    DISP_W  = 6,
  parameter int    ACC_W   = 12,
  parameter lane_e PARITY  = LANE_EVEN
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    bal_en,
  input  logic                    s1_vld,
  input  logic [COLOR_W-1:0]      color,
  input  logic                    tbl_we,
  input  logic [COLOR_W:0]        tbl_waddr,
  input  logic [SYM_W+DISP_W-1:0] tbl_wdata,
  output logic [SYM_W-1:0]        sym,
  output logic [ACC_W-1:0]        acc
);
  localparam int EW = SYM_W + DISP_W;
  localparam int AW = COLOR_W + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [EW-1:0]     rd_word;
  logic [DISP_W-1:0] disp;
  logic [ACC_W:0]    sum;
  logic [ACC_W-1:0]  sat;
  logic [ACC_W-1:0]  eff;
  logic [ACC_W-1:0]  acc_q;
  logic              sgn;
  logic [AW-1:0]     rd_addr;

  assign disp = rd_word[EW-1:SYM_W];

  always_comb begin
    sum = {acc_q[ACC_W-1], acc_q} +
          {{(ACC_W+1-DISP_W){disp[DISP_W-1]}}, disp};
    if (sum[ACC_W] != sum[ACC_W-1]) sat = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    else                            sat = sum[ACC_W-1:0];
    if (clr)                  eff = '0;
    else if (s1_vld && bal_en) eff = sat;
    else                      eff = acc_q;
    sgn = bal_en ? eff[ACC_W-1] : (PARITY == LANE_ODD);
  end

  assign rd_addr = {sgn, color};

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= eff;
  end

  lte_tbl_ram #(.AW(AW), .DW(EW)) u_ram (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  assign sym = rd_word[SYM_W-1:0];
  assign acc = acc_q;
endmodule

// File: rtl/lut_tmds_pair_enc.sv
module lut_tmds_pair_enc import lte_pkg::*; #(
  parameter int COLOR_W = 6,
  parameter int SYM_W   = 10,
  parameter int DISP_W  = 6,
  parameter int ACC_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_line,
  input  logic                    bal_en,
  input  logic                    tbl_we,
  input  logic [COLOR_W:0]        tbl_waddr,
  input  logic [SYM_W+DISP_W-1:0] tbl_wdata,
  input  logic                    in_valid,
  input  logic [2*COLOR_W-1:0]    in_pix,
  output logic                    out_valid,
  output logic [2*SYM_W-1:0]      out_sym
);
  localparam int LANES = 2;

  logic                     s1_vld;
  logic [LANES*SYM_W-1:0]   sym_flat;
  logic [LANES*ACC_W-1:0]   acc_flat;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= in_valid;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lte_lane #(
      .COLOR_W (COLOR_W),
      .SYM_W   (SYM_W),
      .DISP_W  (DISP_W),
      .ACC_W   (ACC_W),
      .PARITY  ((g == 0) ? LANE_EVEN : LANE_ODD)
    ) u_lane (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr_line),
      .bal_en    (bal_en),
      .s1_vld    (s1_vld),
      .color     (in_pix[g*COLOR_W +: COLOR_W]),
      .tbl_we    (tbl_we),
      .tbl_waddr (tbl_waddr),
      .tbl_wdata (tbl_wdata),
      .sym       (sym_flat[g*SYM_W +: SYM_W]),
      .acc       (acc_flat[g*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) out_sym <= sym_flat;
    end
  end
endmodule

// File: rtl/lte_chk.sv
module lte_chk #(
  parameter int DISP_W = 6,
  parameter int ACC_W  = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             clr_line,
  input logic             bal_en,
  input logic             out_valid,
  input logic [2*ACC_W-1:0] acc_flat
);
  localparam logic signed [ACC_W:0] STEP_LO = -(2**(DISP_W-1));
  localparam logic signed [ACC_W:0] STEP_HI = (2**(DISP_W-1)) - 1;

  logic [ACC_W-1:0] acc_e, acc_o, prv_e, prv_o;
  logic signed [ACC_W:0] de_e, de_o;
  logic step_ok;

  assign acc_e = acc_flat[ACC_W-1:0];
  assign acc_o = acc_flat[2*ACC_W-1:ACC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      prv_e <= '0;
      prv_o <= '0;
    end else begin
      prv_e <= acc_e;
      prv_o <= acc_o;
    end
  end

  assign de_e = $signed({acc_e[ACC_W-1], acc_e}) - $signed({prv_e[ACC_W-1], prv_e});
  assign de_o = $signed({acc_o[ACC_W-1], acc_o}) - $signed({prv_o[ACC_W-1], prv_o});
  assign step_ok = (de_e >= STEP_LO) && (de_e <= STEP_HI) &&
                   (de_o >= STEP_LO) && (de_o <= STEP_HI);

  // R2: every accepted pair yields a valid output two edges later
  a_r2_out_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  // R2: no output without an accepted pair
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  // R5: clear zeroes both accumulators
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_line |=> (acc_e == '0 && acc_o == '0));
  // R6: with feedback off the accumulators hold
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!bal_en && !clr_line) |=> ($stable(acc_e) && $stable(acc_o)));
  // R7: accumulators move by at most one disparity per cycle, never wrap
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !clr_line |=> step_ok);
endmodule

bind lut_tmds_pair_enc lte_chk #(.DISP_W(DISP_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .clr_line  (clr_line),
  .bal_en    (bal_en),
  .out_valid (out_valid),
  .acc_flat  (acc_flat)
);

// File: tb/lut_tmds_pair_enc_bench.sv
module lut_tmds_pair_enc_bench;
  logic        clk = 1'b0;
  logic        rst, clr_line, bal_en, tbl_we, in_valid;
  logic [6:0]  tbl_waddr;
  logic [15:0] tbl_wdata;
  logic [11:0] in_pix;
  logic        out_valid;
  logic [19:0] out_sym;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  lut_tmds_pair_enc u_lut_tmds_pair_enc (
    .clk(clk), .rst(rst), .clr_line(clr_line), .bal_en(bal_en),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_sym(out_sym)
  );

  // reference model state
  logic [15:0] mtbl [128];
  logic [15:0] m_rd [2];
  int          macc [2];
  logic        m_s1, m_ov;
  logic [19:0] m_out;

  function automatic int sat12(input int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic [11:0] p, input logic c,
                     input logic b, input logic w, input logic [6:0] wa,
                     input logic [15:0] wd, input string tag);
    logic [15:0] nrd [2];
    int eff [2];
    in_valid = v; in_pix = p; clr_line = c; bal_en = b;
    tbl_we = w; tbl_waddr = wa; tbl_wdata = wd;
    for (int l = 0; l < 2; l++) begin
      logic [5:0] col;
      logic       sg;
      int         d;
      col = (l == 0) ? p[5:0] : p[11:6];
      d = $signed(m_rd[l][15:10]);
      if (c)               eff[l] = 0;
      else if (m_s1 && b)  eff[l] = sat12(macc[l] + d);
      else                 eff[l] = macc[l];
      sg = b ? (eff[l] < 0) : (l == 1);
      nrd[l] = mtbl[{sg, col}];
    end
    if (m_s1) m_out = {m_rd[1][9:0], m_rd[0][9:0]};
    m_ov = m_s1;
    for (int l = 0; l < 2; l++) begin
      macc[l] = eff[l];
      m_rd[l] = nrd[l];
    end
    m_s1 = v;
    if (w) mtbl[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    chk("R2", {31'd0, out_valid}, {31'd0, m_ov});
    if (m_ov) chk(tag, {12'd0, out_sym}, {12'd0, m_out});
  endtask

  task automatic load(input int kind);
    for (int a = 0; a < 128; a++) begin
      logic [15:0] e;
      logic [5:0]  dp;
      case (kind)
        0: e = {6'd0, 10'((a * 5 + 1) & 10'h3ff)};
        1: begin
             if (a[6]) dp = 6'($urandom % 32);
             else      dp = 6'(-($urandom % 33));
             e = {dp, 10'($urandom)};
           end
        2: e = {6'd31, 10'(a)};
        default: e = {6'b100000, 10'(a)};
      endcase
      cyc(1'b0, 12'd0, 1'b0, 1'b1, 1'b1, 7'(a), e, "R8");
    end
  endtask

  task automatic idle(input int n, input logic b);
    for (int i = 0; i < n; i++) cyc(1'b0, 12'd0, 1'b0, b, 1'b0, 7'd0, 16'd0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; clr_line = 0; bal_en = 1; tbl_we = 0; tbl_waddr = 0;
    tbl_wdata = 0; in_valid = 0; in_pix = 0;
    macc[0] = 0; macc[1] = 0; m_s1 = 0; m_ov = 0; m_out = 0;
    m_rd[0] = 0; m_rd[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9", {31'd0, out_valid}, 32'd0);
    chk("R9", {12'd0, out_sym}, 32'd0);

    // R1: zero-disparity table, field layout and address
    load(0);
    for (int i = 0; i < 16; i++)
      cyc(1'b1, 12'($urandom), 1'b0, 1'b1, 1'b0, 7'd0, 16'd0, "R1");
    idle(2, 1'b1);

    // R3 / R4: random table, back-to-back pairs with feedback
    load(1);
    for (int i = 0; i < 200; i++)
      cyc(1'b1, 12'($urandom), 1'b0, 1'b1, 1'b0, 7'd0, 16'd0, "R3");
    for (int i = 0; i < 100; i++)
      cyc(1'b1, {1'b1, 5'($urandom), 1'b0, 5'($urandom)}, 1'b0, 1'b1,
          1'b0, 7'd0, 16'd0, "R4");

    // R5: clear together with a pixel, mid stream
    for (int i = 0; i < 60; i++)
      cyc(1'b1, 12'($urandom), (i % 20) == 7, 1'b1, 1'b0, 7'd0, 16'd0, "R5");
    idle(2, 1'b1);

    // R6: feedback disabled
    idle(1, 1'b0);
    for (int i = 0; i < 60; i++)
      cyc($urandom % 4 != 0, 12'($urandom), 1'b0, 1'b0, 1'b0, 7'd0, 16'd0, "R6");
    idle(2, 1'b0);
    idle(1, 1'b1);

    // R8: same-cycle write returns old contents, next lookup sees new
    idle(1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic [5:0] c6;
      c6 = 6'($urandom);
      cyc(1'b1, {6'd0, c6}, 1'b0, 1'b0, 1'b1, {1'b0, c6}, 16'($urandom), "R8");
      cyc(1'b1, {6'd0, c6}, 1'b0, 1'b0, 1'b0, 7'd0, 16'd0, "R8");
    end
    idle(2, 1'b0);
    idle(1, 1'b1);

    // R7: drive to positive saturation, then back down
    cyc(1'b0, 12'd0, 1'b1, 1'b1, 1'b0, 7'd0, 16'd0, "R5");
    load(2);
    for (int i = 0; i < 80; i++)
      cyc(1'b1, 12'($urandom), 1'b0, 1'b1, 1'b0, 7'd0, 16'd0, "R7");
    idle(2, 1'b1);
    load(3);
    for (int i = 0; i < 70; i++)
      cyc(1'b1, 12'($urandom), 1'b0, 1'b1, 1'b0, 7'd0, 16'd0, "R7");
    idle(2, 1'b1);

    // mixed random traffic
    load(1);
    cyc(1'b0, 12'd0, 1'b1, 1'b1, 1'b0, 7'd0, 16'd0, "R5");
    for (int i = 0; i < 400; i++)
      cyc($urandom % 5 != 0, 12'($urandom), ($urandom % 32) == 0, 1'b1,
          ($urandom % 16) == 0, 7'($urandom), {6'($urandom % 32), 10'($urandom)}, "R3");
    idle(3, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule